// File: doc/BRIEF.md
# Link Self-Test Frame Error Monitor

This block sits on the receive side of a serial link and checks a test stream during a self-test session. A session opens when the test enable input and the receiver lock input are both high. While the session runs, each payload beat that arrives on a valid/ready stream is compared with a locally generated pseudo-random reference. Every frame that holds at least one wrong bit produces one short low pulse on the `pass_o` status pin and adds one to a saturating error count. When the enable drops, checking stops and the link goes back to normal traffic. `pass_o` then shows the session verdict for a fixed window before it returns to its idle low level. The error count keeps its value until a new session opens or reset is applied.

The block also produces the test-clock source selection. A mode input chooses whether the 2-bit selection comes from the pin inputs or from register bits. The two sources map codes 01 and 10 to different frequencies.

The input stream follows valid/ready rules. `rx_ready` is high only while a session is open, enable is high and lock is present. A beat is consumed on a clock edge where both `rx_valid` and `rx_ready` are high. The sender must hold a beat until it is consumed. The checker never applies back-pressure inside a running, locked session. Outside a session, `rx_ready` stays low and the stream is left to the normal data path.

Top module: `bist_frame_monitor`

## Requirements
- R1: A session opens on the first clock edge where `bist_en` and `rx_lock` are both high and no session is open. In the cycle after that edge, `bist_active`, `rx_ready` and `pass_o` are 1 and `err_count` is 0. While `rx_lock` is low, no session opens and `rx_ready` stays 0.
- R2: The reference is a 7-bit LFSR with polynomial x^7+x^6+1. Its state is s[6:0], its output bit is s[6] and the next state is {s[5:0], s[6]^s[5]}. It starts from seed 7'h5B at the first beat of each frame. Bit 0 of each beat is compared first, then bit 1 and so on up to the top bit. A frame ends with the beat that has `rx_last` set. The frame is errored if any bit of any of its beats differs from the reference. A frame without errors changes neither `pass_o` nor `err_count`.
- R3: The last beat of an errored frame is consumed at edge k. `pass_o` is then low in the two cycles that follow edge k+1, and high again after that.
- R4: Errored frames that arrive back to back each give a separate low pulse. Two pulses are always separated by at least two high cycles. Events that arrive while a pulse is in progress are queued, so none is lost up to a queue depth of 15.
- R5: `err_count` rises by exactly 1 per errored frame, with the new value visible after edge k+1. It stops at 255 and never wraps.
- R6: After the session ends, `err_count` keeps its value. It is cleared only by reset or by the opening of a new session.
- R7: When `bist_en` is seen low at edge e during a session, `pass_o` shows the verdict for the 16 cycles after e. The verdict is 1 if `err_count` is 0 and 0 otherwise. From edge e+16 on, `pass_o` is 0.
- R8: Once `bist_en` is seen low at an edge, `bist_active` and `rx_ready` are 0 in the next cycle, and no further beats are consumed.
- R9: `clk_src` is 0 (external clock) while `bist_en` is low. Otherwise `clk_src` uses encoding 0=external, 1=~50 MHz, 2=~25 MHz, 3=~12.5 MHz. When `cfg_pin_mode`=1, the value comes from `pin_sel` as 00→0, 01→2, 10→1, 11→3. When `cfg_pin_mode`=0, it is `reg_sel` unchanged.
- R10: While reset is held and right after it, `pass_o`, `bist_active`, `rx_ready` and `err_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bist_en | input | 1 | Self-test enable |
| rx_lock | input | 1 | Receiver lock indication |
| cfg_pin_mode | input | 1 | 1: clock select from pins, 0: from register bits |
| pin_sel | input | 2 | Clock select code from pins |
| reg_sel | input | 2 | Clock select code from register bits |
| rx_valid | input | 1 | Payload beat valid |
| rx_data | input | DATA_W | Payload beat, bit 0 compared first |
| rx_last | input | 1 | Beat closes a frame |
| rx_ready | output | 1 | Beat can be consumed |
| bist_active | output | 1 | Session open; link is in test mode |
| pass_o | output | 1 | Status pin: run level, error pulses, verdict |
| err_count | output | CNT_W | Saturating count of errored frames |
| clk_src | output | 2 | Selected test-clock source |

## Verification
Session opening and closing each show on the ports one cycle after the edge that sees the enable change. A frame verdict takes two registers: the compare stage, then the counter and pulse timer. So both the count and the start of the low pulse appear one cycle after the edge that consumes the closing beat. The verdict window covers the 16 cycles after the stop edge. The bench drives inputs on falling edges and samples at the next falling edge, or at the one after it, to match these delays. A monitor counts the falling edges of `pass_o` and measures the lengths of its low and high runs during a session. The clock select is combinational and is checked right after the inputs are driven.

// File: rtl/bist_mon_pkg.sv
package bist_mon_pkg;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_50M  = 2'd1,
    SRC_25M  = 2'd2,
    SRC_12M5 = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_RUN     = 2'd1,
    PS_VERDICT = 2'd2
  } pass_state_e;

  localparam logic [6:0] PRBS_SEED = 7'h5B;

  // one step of x^7 + x^6 + 1, output taken from the top bit
  function automatic logic [6:0] prbs7_next(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

endpackage

// File: rtl/bist_frame_cmp.sv
module bist_frame_cmp
  import bist_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              beat_take,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              beat_last,
  output logic              frame_bad
);

  logic [6:0]        lfsr_q;
  logic [6:0]        lfsr_adv;
  logic [DATA_W-1:0] ref_word;
  logic              acc_q;
  logic              beat_bad;

  always_comb begin
    logic [6:0] s;
    s = lfsr_q;
    for (int i = 0; i < DATA_W; i++) begin
      ref_word[i] = s[6];
      s = prbs7_next(s);
    end
    lfsr_adv = s;
  end

  assign beat_bad = (beat_data != ref_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q    <= PRBS_SEED;
      acc_q     <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      frame_bad <= 1'b0;
      if (restart) begin
        lfsr_q <= PRBS_SEED;
        acc_q  <= 1'b0;
      end else if (beat_take) begin
        if (beat_last) begin
          frame_bad <= acc_q | beat_bad;
          acc_q     <= 1'b0;
          lfsr_q    <= PRBS_SEED;
        end else begin
          acc_q  <= acc_q | beat_bad;
          lfsr_q <= lfsr_adv;
        end
      end
    end
  end

endmodule

// File: rtl/bist_err_counter.sv
module bist_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count <= '0;
    else if (clear)                     count <= '0;
    else if (bump && count != CNT_MAX)  count <= count + 1'b1;
  end

endmodule

// File: rtl/bist_pass_shaper.sv
module bist_pass_shaper
  import bist_mon_pkg::*;
#(
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2,
  parameter int VERD_CYC = 16,
  parameter int PEND_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic err_evt,
  input  logic all_clean,
  output logic pass_o
);

  localparam int TMR_W = $clog2(LOW_CYC + HIGH_CYC + 1);
  localparam int VRD_W = $clog2(VERD_CYC + 1);
  localparam logic [TMR_W-1:0]  TMR_LOAD = TMR_W'(LOW_CYC + HIGH_CYC);
  localparam logic [TMR_W-1:0]  TMR_HIGH = TMR_W'(HIGH_CYC);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  pass_state_e       st_q;
  logic [PEND_W-1:0] pend_q, pend_n;
  logic [TMR_W-1:0]  tmr_q;
  logic [VRD_W-1:0]  vcnt_q;
  logic              take;

  assign take = (tmr_q <= TMR_W'(1)) && ((pend_q != '0) || err_evt);

  always_comb begin
    logic [PEND_W:0] sum;
    sum = {1'b0, pend_q} + {{PEND_W{1'b0}}, err_evt};
    if (take) sum = sum - 1'b1;
    pend_n = (sum > {1'b0, PEND_MAX}) ? PEND_MAX : sum[PEND_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      pend_q <= '0;
      tmr_q  <= '0;
      vcnt_q <= '0;
    end else if (start) begin
      st_q   <= PS_RUN;
      pend_q <= '0;
      tmr_q  <= '0;
    end else if (stop) begin
      st_q   <= PS_VERDICT;
      pend_q <= '0;
      tmr_q  <= '0;
      vcnt_q <= VRD_W'(VERD_CYC - 1);
    end else begin
      case (st_q)
        PS_RUN: begin
          pend_q <= pend_n;
          if (take)              tmr_q <= TMR_LOAD;
          else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
        end
        PS_VERDICT: begin
          if (vcnt_q == '0) st_q <= PS_IDLE;
          else              vcnt_q <= vcnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      PS_RUN:     pass_o = !(tmr_q > TMR_HIGH);
      PS_VERDICT: pass_o = all_clean;
      default:    pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bist_clk_select.sv
module bist_clk_select
  import bist_mon_pkg::*;
(
  input  logic       bist_en,
  input  logic       cfg_pin_mode,
  input  logic [1:0] pin_sel,
  input  logic [1:0] reg_sel,
  output logic [1:0] clk_src
);

  clk_src_e from_pin;

  always_comb begin
    case (pin_sel)
      2'b01:   from_pin = SRC_25M;
      2'b10:   from_pin = SRC_50M;
      2'b11:   from_pin = SRC_12M5;
      default: from_pin = SRC_EXT;
    endcase
    if (!bist_en)          clk_src = SRC_EXT;
    else if (cfg_pin_mode) clk_src = from_pin;
    else                   clk_src = reg_sel;
  end

endmodule

// File: rtl/bist_frame_monitor.sv
module bist_frame_monitor
  import bist_mon_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2,
  parameter int VERD_CYC = 16,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic              rx_lock,
  input  logic              cfg_pin_mode,
  input  logic [1:0]        pin_sel,
  input  logic [1:0]        reg_sel,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              bist_active,
  output logic              pass_o,
  output logic [CNT_W-1:0]  err_count,
  output logic [1:0]        clk_src
);

  logic sess_q;
  logic start, stop, take_beat, frame_bad;

  assign start       = bist_en && rx_lock && !sess_q;
  assign stop        = sess_q && !bist_en;
  assign rx_ready    = sess_q && bist_en && rx_lock;
  assign take_beat   = rx_valid && rx_ready;
  assign bist_active = sess_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sess_q <= 1'b0;
    else if (start) sess_q <= 1'b1;
    else if (stop)  sess_q <= 1'b0;
  end

  bist_frame_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .restart(start), .beat_take(take_beat),
    .beat_data(rx_data), .beat_last(rx_last), .frame_bad(frame_bad)
  );

  bist_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start), .bump(frame_bad), .count(err_count)
  );

  bist_pass_shaper #(
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .VERD_CYC(VERD_CYC), .PEND_W(PEND_W)
  ) u_pass (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .err_evt(frame_bad),
    .all_clean(err_count == '0), .pass_o(pass_o)
  );

  bist_clk_select u_sel (
    .bist_en(bist_en), .cfg_pin_mode(cfg_pin_mode), .pin_sel(pin_sel),
    .reg_sel(reg_sel), .clk_src(clk_src)
  );

endmodule

// File: rtl/bist_mon_props.sv
module bist_mon_props #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bist_en,
  input logic             rx_lock,
  input logic             rx_ready,
  input logic             bist_active,
  input logic             pass_o,
  input logic [CNT_W-1:0] err_count,
  input logic [1:0]       clk_src
);

  assert_session_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_active) |-> (pass_o && rx_ready && err_count == '0));

  assert_ready_needs_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lock |-> !rx_ready);

  assert_pulse_low_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_active && bist_en && $past(bist_active) && $fell(pass_o)) |=> !pass_o);

  assert_gap_high_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_active && bist_en && $past(bist_active) && $rose(pass_o)) |=> pass_o);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count) && !$rose(bist_active))
      |-> (err_count == $past(err_count) + 1'b1));

  assert_count_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bist_active && !$past(bist_active)) |-> $stable(err_count));

  assert_stop_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> (!bist_active && !rx_ready));

  assert_clk_idle_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |-> (clk_src == 2'd0));

endmodule

bind bist_frame_monitor bist_mon_props #(.CNT_W(CNT_W)) u_props (.*);

// File: tb/sim_bist_frame_monitor.sv
module sim_bist_frame_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bist_en = 1'b0, rx_lock = 1'b0, cfg_pin_mode = 1'b0;
  logic [1:0]    pin_sel = '0, reg_sel = '0;
  logic          rx_valid = 1'b0, rx_last = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_ready, bist_active, pass_o;
  logic [7:0]    err_count;
  logic [1:0]    clk_src;

  int checks = 0, errors = 0, exp_cnt = 0;
  int falls = 0, bad_low = 0, bad_high = 0, low_run = 0, high_run = 0;
  logic prev_pass = 1'b0, prev_act = 1'b0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_frame_monitor #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .rx_lock(rx_lock),
    .cfg_pin_mode(cfg_pin_mode), .pin_sel(pin_sel), .reg_sel(reg_sel),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_ready(rx_ready), .bist_active(bist_active), .pass_o(pass_o),
    .err_count(err_count), .clk_src(clk_src)
  );

  // pulse monitor: falling edges and run lengths while a session stays open
  always @(negedge clk) begin
    if (bist_active && prev_act) begin
      if (prev_pass && !pass_o) begin
        falls++;
        if (high_run < 2) bad_high++;
        low_run = 1;
      end else if (!prev_pass && pass_o) begin
        if (low_run != 2) bad_low++;
        high_run = 1;
      end else if (!pass_o) low_run++;
      else high_run++;
    end else begin
      high_run = 2;
      low_run  = 0;
    end
    prev_pass = pass_o;
    prev_act  = bist_active;
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] ref_word(input int beat);
    logic [6:0] s = 7'h5B;
    logic [DW-1:0] w = '0;
    for (int i = 0; i < beat * DW; i++) s = {s[5:0], s[6] ^ s[5]};
    for (int i = 0; i < DW; i++) begin
      w[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return w;
  endfunction

  task automatic send_frame(input int len, input int bad_pos, input int bad_bit);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = ref_word(b) ^ ((b == bad_pos) ? DW'(1 << bad_bit) : DW'(0));
      rx_last  = (b == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    if (bad_pos >= 0 && exp_cnt < 255) exp_cnt++;
  endtask

  task automatic open_session();
    @(negedge clk);
    bist_en = 1'b1;
    rx_lock = 1'b1;
    @(negedge clk);
    exp_cnt = 0;
    check(int'(bist_active), 1, "R1 active");
    check(int'(rx_ready), 1, "R1 ready");
    check(int'(pass_o), 1, "R1 pass high");
    check(int'(err_count), 0, "R1/R6 count cleared");
  endtask

  task automatic close_and_verdict(input int exp_v);
    @(negedge clk);
    bist_en = 1'b0;
    @(negedge clk);
    check(int'(bist_active), 0, "R8 inactive");
    check(int'(rx_ready), 0, "R8 ready low");
    check(int'(pass_o), exp_v, "R7 verdict first");
    repeat (15) @(negedge clk);
    check(int'(pass_o), exp_v, "R7 verdict last");
    @(negedge clk);
    check(int'(pass_o), 0, "R7 idle after verdict");
    check(int'(err_count), exp_cnt, "R6 count retained");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    check(int'(pass_o), 0, "R10 pass in reset");
    check(int'(err_count), 0, "R10 count in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(bist_active), 0, "R10 active");
    check(int'(rx_ready), 0, "R10 ready");
    check(int'(clk_src), 0, "R10 clk_src");

    // R9: full sweep of select inputs, lock held low so no session opens
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 4; p++)
          for (int r = 0; r < 4; r++) begin
            int exp;
            @(negedge clk);
            bist_en = e[0]; cfg_pin_mode = m[0]; pin_sel = p[1:0]; reg_sel = r[1:0];
            #1;
            if (e == 0)      exp = 0;
            else if (m == 1) exp = (p == 1) ? 2 : (p == 2) ? 1 : p;
            else             exp = r;
            check(int'(clk_src), exp, "R9 clock select");
          end

    // R1: enable without lock does not open a session
    @(negedge clk); bist_en = 1'b1; rx_lock = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(bist_active), 0, "R1 no lock no session");
    check(int'(rx_ready), 0, "R1 no lock no ready");
    check(int'(pass_o), 0, "R1 no lock pass low");
    bist_en = 1'b0;

    open_session();

    // R2 clean frames, R3/R5 single-bit errors at every beat and bit
    for (int len = 1; len <= 3; len++) begin
      f0 = falls;
      send_frame(len + 1, -1, 0);
      @(negedge clk);
      check(err_count, exp_cnt, "R2 clean frame count");
      repeat (5) @(negedge clk);
      check(falls, f0, "R2 clean frame no pulse");
      for (int pos = 0; pos < len; pos++)
        for (int bt = 0; bt < DW; bt++) begin
          f0 = falls;
          send_frame(len, pos, bt);
          check(int'(pass_o), 1, "R3 high before pulse");
          check(int'(err_count), exp_cnt - 1, "R5 count not yet");
          @(negedge clk);
          check(int'(pass_o), 0, "R3 low first cycle");
          check(int'(err_count), exp_cnt, "R5 count step");
          @(negedge clk);
          check(int'(pass_o), 0, "R3 low second cycle");
          @(negedge clk);
          check(int'(pass_o), 1, "R3 high after pulse");
          repeat (3) @(negedge clk);
          check(falls, f0 + 1, "R3 one pulse per frame");
        end
    end

    // R4: five errored one-beat frames back to back
    f0 = falls;
    for (int i = 0; i < 5; i++) send_frame_bb(i);
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    repeat (30) @(negedge clk);
    check(falls, f0 + 5, "R4 separate pulses");
    check(err_count, exp_cnt, "R5 back to back count");
    check(bad_low, 0, "R3 low width two");
    check(bad_high, 0, "R4 gap at least two");

    close_and_verdict(0);
    // R8: beats offered after stop are not consumed
    send_frame(1, 0, 0);
    exp_cnt--;
    repeat (3) @(negedge clk);
    check(int'(err_count), exp_cnt, "R8 no checking after stop");

    open_session();
    send_frame(3, -1, 0);
    send_frame(2, -1, 0);
    close_and_verdict(1);

    // R5 saturation
    open_session();
    for (int i = 0; i < 260; i++) send_frame_bb(i);
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
    check(int'(err_count), 255, "R5 saturates");
    close_and_verdict(0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // one-beat errored frame, valid left high for back-to-back streaming
  task automatic send_frame_bb(input int i);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_last  = 1'b1;
    rx_data  = ref_word(0) ^ DW'(1 << (i % DW));
    if (exp_cnt < 255) exp_cnt++;
  endtask

endmodule